// File: doc/BRIEF.md
# Inter-Block Register Forwarding Bank

This block is one bank of a distributed register file. It keeps a set of architectural registers for each hardware thread. Beside them sit a write queue and a read queue for each block slot in flight, and one block slot holds a block of instructions that may execute speculatively. Write instructions from a block header are placed in the write queue when the block is dispatched. Their values arrive later, out of order, and reach the architectural registers only when the block commits. Read instructions are placed in the read queue and are resolved at once. Each one searches the write queues of the older live blocks of its own thread and then takes one of three paths: it reads the register file, it forwards a value that has already arrived, or it waits until the value of the pending write arrives.

Satisfied reads leave through a single operand port, one per cycle, tagged with the consumer tag given at insertion. A commit copies the block's written values into the register file, one entry per cycle, and then frees the slot. A flush frees every slot in a mask. A parked read whose write was flushed searches the queues again. The bank also reports write completion for a block onward. It does so once the block's expected writes have all received values here and the neighbouring bank has reported the same block.

Top module: `rf_fwd_bank`

## Requirements
- R1: After reset no operand and no completion is reported, a commit is accepted (`cmt_ready` high), and every register of every thread reads as zero.
- R2: A read with no matching write in an older live block of its thread returns the architectural register value for its own thread and register index.
- R3: A read whose matching older write already holds its value returns that value without waiting for commit.
- R4: A read whose matching older write has no value yet produces no operand until that value arrives, and then returns exactly that value.
- R5: When several older blocks of the same thread write the register, the youngest of them that is still older than the reader supplies the value. Writes in younger blocks and in other threads are not considered.
- R6: A write in the reader's own block is never forwarded to that read, even when it holds a value.
- R7: A commit keeps `cmt_ready` low for exactly QD cycles. It writes the block's valued writes into the register file through a single write port, so later reads see them from the file.
- R8: A flush frees the masked slots. A read parked on a flushed write searches again and takes the next older write or the file value. A value that arrives later for a flushed write is ignored.
- R9: `cout_vld` pulses exactly once per block, carrying the block slot in `cout_blk`, once all expected writes of the block hold values and `cin_vld` has named the block, in either order. A block expecting zero writes needs only the neighbour report.
- R10: Every inserted read that is not flushed yields exactly one operand on `op_vld`, carrying its own tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| open_vld | input | 1 | Allocate a free block slot |
| open_blk | input | BW | Slot being allocated |
| open_thr | input | TW | Thread owning the block |
| open_nwr | input | CW | Number of writes the block will send to this bank |
| wins_vld | input | 1 | Insert a write instruction |
| wins_blk | input | BW | Block slot of the write |
| wins_slot | input | SW | Write-queue entry within the block |
| wins_reg | input | RW | Destination register index |
| rins_vld | input | 1 | Insert a read instruction |
| rins_blk | input | BW | Block slot of the read |
| rins_slot | input | SW | Read-queue entry within the block |
| rins_reg | input | RW | Source register index |
| rins_tag | input | TAGW | Consumer tag returned with the operand |
| wval_vld | input | 1 | A write value arrives |
| wval_blk | input | BW | Block slot of the write |
| wval_slot | input | SW | Write-queue entry |
| wval_data | input | DW | Value |
| cmt_vld | input | 1 | Commit a block |
| cmt_blk | input | BW | Block slot to commit |
| cmt_ready | output | 1 | High when a commit may be issued |
| flush_vld | input | 1 | Flush command |
| flush_mask | input | NBLK | One bit per slot to flush |
| cin_vld | input | 1 | Neighbour reports write completion |
| cin_blk | input | BW | Block slot of the neighbour report |
| cout_vld | output | 1 | Write completion reported onward |
| cout_blk | output | BW | Block slot of that report |
| op_vld | output | 1 | Operand output valid |
| op_tag | output | TAGW | Consumer tag of the operand |
| op_data | output | DW | Operand value |

## Verification
The assertions check on every cycle that a commit lowers `cmt_ready` for exactly QD cycles, that a flush leaves no write-queue entry alive in a masked slot, that completion is never reported twice in a row for one slot, and that the outputs are quiet when reset ends. The forwarding choices can be shown only by the bench's scenarios: the file path, forwarding of a ready value, parking, the youngest older writer, own-block and other-thread exclusion, and re-resolution after a flush. These scenarios build chains of blocks with known write values and compare every tagged operand against values computed from the register index and thread.

// File: rtl/rf_fwd_pkg.sv
// Shared types for the register forwarding bank.
// Assumes nothing beyond IEEE 1800-2017 enums.
package rf_fwd_pkg;

    // Life cycle of a read-queue entry
    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,   // empty or already delivered
        RS_NEW  = 2'd1,   // inserted, waiting for a resolver
        RS_PARK = 2'd2,   // waiting for a pending write's value
        RS_RDY  = 2'd3    // value held, waiting for the output port
    } rd_state_e;

endpackage

// File: rtl/rf_age_matrix.sv
// Tracks relative age of block slots.
// older[i][j] is set when slot i was live at the moment slot j was opened,
// so i is older than j. Stale rows of freed slots are masked by users
// through their own liveness vector.
module rf_age_matrix #(
    parameter int NBLK = 8,
    parameter int BW   = $clog2(NBLK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            open_vld,
    input  logic [BW-1:0]   open_blk,
    input  logic [NBLK-1:0] blk_vld,
    output logic [NBLK-1:0] older [NBLK]
);

    // Record a new slot as younger than every live slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) older[i] <= '0;
        end else if (open_vld) begin
            for (int i = 0; i < NBLK; i++) begin
                older[i][open_blk] <= blk_vld[i];
                older[open_blk][i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rf_wq_search.sv
// Associative search of all write queues for one read.
// Finds writes to the same register in live, older blocks of the same
// thread and keeps the youngest such block. Assumes a block writes a
// given register at most once. A value arriving this cycle for the chosen
// entry counts as present (bypass).
module rf_wq_search #(
    parameter int NBLK = 8,
    parameter int QD   = 8,
    parameter int RW   = 5,
    parameter int TW   = 2,
    parameter int DW   = 64,
    parameter int BW   = $clog2(NBLK),
    parameter int NE   = NBLK * QD,
    parameter int EW   = $clog2(NE)
) (
    input  logic [BW-1:0]   rd_blk,
    input  logic [TW-1:0]   rd_thr,
    input  logic [RW-1:0]   rd_reg,
    input  logic [NBLK-1:0] live,
    input  logic [TW-1:0]   blk_thr [NBLK],
    input  logic [NBLK-1:0] older   [NBLK],
    input  logic [NE-1:0]   wq_vld,
    input  logic [NE-1:0]   wq_hv,
    input  logic [RW-1:0]   wq_reg  [NE],
    input  logic [DW-1:0]   wq_data [NE],
    input  logic            byp_vld,
    input  logic [EW-1:0]   byp_e,
    input  logic [DW-1:0]   byp_data,
    output logic            hit,
    output logic            hit_rdy,
    output logic [EW-1:0]   hit_e,
    output logic [DW-1:0]   hit_data
);

    logic [NBLK-1:0] cand;
    logic [EW-1:0]   cand_e [NBLK];

    // Per block: does an older same-thread block write this register
    always_comb begin
        for (int b = 0; b < NBLK; b++) begin
            cand[b]   = 1'b0;
            cand_e[b] = '0;
            for (int s = 0; s < QD; s++) begin
                if (live[b] && blk_thr[b] == rd_thr && older[b][rd_blk] &&
                    wq_vld[b*QD+s] && wq_reg[b*QD+s] == rd_reg) begin
                    cand[b]   = 1'b1;
                    cand_e[b] = EW'(b*QD+s);
                end
            end
        end
    end

    // Keep the candidate with no younger candidate, then check its value
    always_comb begin
        hit   = 1'b0;
        hit_e = '0;
        for (int b = 0; b < NBLK; b++) begin
            if (cand[b] && ((cand & older[b]) == '0)) begin
                hit   = 1'b1;
                hit_e = cand_e[b];
            end
        end
        hit_rdy  = hit && (wq_hv[hit_e] || (byp_vld && byp_e == hit_e));
        hit_data = wq_hv[hit_e] ? wq_data[hit_e] : byp_data;
    end

endmodule

// File: rtl/rf_bank_store.sv
// Architectural register storage: two combinational read ports and one
// write port. Cleared to zero by reset.
module rf_bank_store #(
    parameter int DEPTH = 128,
    parameter int DW    = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra0,
    output logic [DW-1:0] rd0,
    input  logic [AW-1:0] ra1,
    output logic [DW-1:0] rd1,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);

    logic [DW-1:0] mem [DEPTH];

    // Single write port, cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    // Two independent read ports
    always_comb begin
        rd0 = mem[ra0];
        rd1 = mem[ra1];
    end

endmodule

// File: rtl/rf_done_chain.sv
// Write-completion relay: reports a block onward once its local writes
// are all valued and the neighbour has reported it. One report per cycle,
// lowest slot first; each block is reported once per allocation.
module rf_done_chain #(
    parameter int NBLK = 8,
    parameter int BW   = $clog2(NBLK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            open_vld,
    input  logic [BW-1:0]   open_blk,
    input  logic [NBLK-1:0] local_done,
    input  logic            cin_vld,
    input  logic [BW-1:0]   cin_blk,
    output logic            cout_vld,
    output logic [BW-1:0]   cout_blk
);

    logic [NBLK-1:0] nbr_seen;
    logic [NBLK-1:0] sent;
    logic            fire;
    logic [BW-1:0]   fire_b;

    // Choose the lowest block ready to report
    always_comb begin
        fire   = 1'b0;
        fire_b = '0;
        for (int b = NBLK-1; b >= 0; b--) begin
            if (local_done[b] && nbr_seen[b] && !sent[b]) begin
                fire   = 1'b1;
                fire_b = BW'(b);
            end
        end
    end

    // Track neighbour reports and sent flags, register the report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nbr_seen <= '0;
            sent     <= '0;
            cout_vld <= 1'b0;
            cout_blk <= '0;
        end else begin
            for (int b = 0; b < NBLK; b++) begin
                if (open_vld && open_blk == BW'(b)) begin
                    nbr_seen[b] <= 1'b0;
                    sent[b]     <= 1'b0;
                end else begin
                    if (cin_vld && cin_blk == BW'(b)) nbr_seen[b] <= 1'b1;
                    if (fire && fire_b == BW'(b))     sent[b]     <= 1'b1;
                end
            end
            cout_vld <= fire;
            cout_blk <= fire_b;
        end
    end

endmodule

// File: rtl/rf_fwd_bank.sv
// Register bank with inter-block forwarding.
// Holds NREG registers per thread for NTHR threads plus QD-entry read and
// write queues per block slot. Reads resolve against older in-flight
// writes (two resolvers per cycle, one per file read port); writes reach
// the file at commit, one per cycle. Assumptions: NTHR, NREG, NBLK and QD
// are powers of two; a block's writes are inserted before any read of a
// younger block of its thread; opens target free slots; commit is issued
// only for a block whose writes all hold values and whose reads are served.
module rf_fwd_bank
    import rf_fwd_pkg::*;
#(
    parameter int DW   = 64,
    parameter int NTHR = 4,
    parameter int NREG = 32,
    parameter int NBLK = 8,
    parameter int QD   = 8,
    parameter int TAGW = 8,
    localparam int TW  = $clog2(NTHR),
    localparam int RW  = $clog2(NREG),
    localparam int BW  = $clog2(NBLK),
    localparam int SW  = $clog2(QD),
    localparam int CW  = $clog2(QD+1),
    localparam int NE  = NBLK * QD,
    localparam int EW  = $clog2(NE),
    localparam int FA  = TW + RW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            open_vld,
    input  logic [BW-1:0]   open_blk,
    input  logic [TW-1:0]   open_thr,
    input  logic [CW-1:0]   open_nwr,
    input  logic            wins_vld,
    input  logic [BW-1:0]   wins_blk,
    input  logic [SW-1:0]   wins_slot,
    input  logic [RW-1:0]   wins_reg,
    input  logic            rins_vld,
    input  logic [BW-1:0]   rins_blk,
    input  logic [SW-1:0]   rins_slot,
    input  logic [RW-1:0]   rins_reg,
    input  logic [TAGW-1:0] rins_tag,
    input  logic            wval_vld,
    input  logic [BW-1:0]   wval_blk,
    input  logic [SW-1:0]   wval_slot,
    input  logic [DW-1:0]   wval_data,
    input  logic            cmt_vld,
    input  logic [BW-1:0]   cmt_blk,
    output logic            cmt_ready,
    input  logic            flush_vld,
    input  logic [NBLK-1:0] flush_mask,
    input  logic            cin_vld,
    input  logic [BW-1:0]   cin_blk,
    output logic            cout_vld,
    output logic [BW-1:0]   cout_blk,
    output logic            op_vld,
    output logic [TAGW-1:0] op_tag,
    output logic [DW-1:0]   op_data
);

    localparam int NRES = 2;

    // Block slot state
    logic [NBLK-1:0] blk_vld;
    logic [TW-1:0]   blk_thr [NBLK];
    logic [CW-1:0]   blk_nwr [NBLK];
    logic [NBLK-1:0] older   [NBLK];
    logic [NBLK-1:0] kill, live, free_v, local_done, wq_blk_any;

    // Write queue
    logic [NE-1:0]   wq_vld, wq_hv;
    logic [RW-1:0]   wq_reg  [NE];
    logic [DW-1:0]   wq_data [NE];

    // Read queue
    rd_state_e       rq_st   [NE];
    logic [RW-1:0]   rq_reg  [NE];
    logic [TAGW-1:0] rq_tag  [NE];
    logic [DW-1:0]   rq_data [NE];
    logic [EW-1:0]   rq_pe   [NE];

    // Flat entry indices of the inputs
    logic [EW-1:0]   wins_e, rins_e, wval_e;

    // Commit walker
    logic            cmt_busy;
    logic [BW-1:0]   cmt_b;
    logic [SW-1:0]   cmt_ptr;
    logic [EW-1:0]   cmt_e;
    logic            cmt_last;
    logic            rf_we;
    logic [FA-1:0]   rf_wa;

    // Resolver picks and results
    logic            pk_v    [NRES];
    logic [EW-1:0]   pk_e    [NRES];
    logic [BW-1:0]   pk_blk  [NRES];
    logic [FA-1:0]   rf_ra   [NRES];
    logic [DW-1:0]   rf_q    [NRES];
    logic            rs_hit  [NRES];
    logic            rs_rdy  [NRES];
    logic [EW-1:0]   rs_e    [NRES];
    logic [DW-1:0]   rs_data [NRES];

    // Output arbitration
    logic            em_vld;
    logic [EW-1:0]   em_e;

    // Index arithmetic, slot liveness and the free vector
    always_comb begin
        wins_e   = EW'(wins_blk) * EW'(QD) + EW'(wins_slot);
        rins_e   = EW'(rins_blk) * EW'(QD) + EW'(rins_slot);
        wval_e   = EW'(wval_blk) * EW'(QD) + EW'(wval_slot);
        cmt_e    = EW'(cmt_b) * EW'(QD) + EW'(cmt_ptr);
        cmt_last = cmt_busy && (cmt_ptr == SW'(QD-1));
        kill     = flush_vld ? flush_mask : '0;
        live     = blk_vld & ~kill;
        free_v   = kill;
        if (cmt_last) free_v[cmt_b] = 1'b1;
        cmt_ready = !cmt_busy;
    end

    // Per-block write bookkeeping: any live entry, all expected values in
    always_comb begin
        for (int b = 0; b < NBLK; b++) begin
            int n;
            n = 0;
            wq_blk_any[b] = 1'b0;
            for (int s = 0; s < QD; s++) begin
                n = n + int'(wq_hv[b*QD+s]);
                wq_blk_any[b] = wq_blk_any[b] | wq_vld[b*QD+s];
            end
            local_done[b] = blk_vld[b] && (n == int'(blk_nwr[b]));
        end
    end

    // Block slot allocation and release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_vld <= '0;
            for (int b = 0; b < NBLK; b++) begin
                blk_thr[b] <= '0;
                blk_nwr[b] <= '0;
            end
        end else begin
            for (int b = 0; b < NBLK; b++) begin
                if (open_vld && open_blk == BW'(b)) begin
                    blk_vld[b] <= 1'b1;
                    blk_thr[b] <= open_thr;
                    blk_nwr[b] <= open_nwr;
                end else if (free_v[b]) begin
                    blk_vld[b] <= 1'b0;
                end
            end
        end
    end

    // Write-queue entries: insert, receive value, release with the block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wq_vld <= '0;
            wq_hv  <= '0;
            for (int e = 0; e < NE; e++) begin
                wq_reg[e]  <= '0;
                wq_data[e] <= '0;
            end
        end else begin
            for (int e = 0; e < NE; e++) begin
                if (free_v[e/QD]) begin
                    wq_vld[e] <= 1'b0;
                    wq_hv[e]  <= 1'b0;
                end
                if (open_vld && open_blk == BW'(e/QD)) begin
                    wq_vld[e] <= 1'b0;
                    wq_hv[e]  <= 1'b0;
                end
                if (wins_vld && wins_e == EW'(e)) begin
                    wq_vld[e] <= 1'b1;
                    wq_hv[e]  <= 1'b0;
                    wq_reg[e] <= wins_reg;
                end else if (wval_vld && wval_e == EW'(e) && wq_vld[e] &&
                             !free_v[e/QD]) begin
                    wq_hv[e]   <= 1'b1;
                    wq_data[e] <= wval_data;
                end
            end
        end
    end

    // Pick up to two unresolved reads: lowest and highest index
    always_comb begin
        pk_v[0] = 1'b0; pk_e[0] = '0;
        pk_v[1] = 1'b0; pk_e[1] = '0;
        for (int e = 0; e < NE; e++) begin
            if (rq_st[e] == RS_NEW && live[e/QD]) begin
                if (!pk_v[0]) begin
                    pk_v[0] = 1'b1;
                    pk_e[0] = EW'(e);
                end
                pk_v[1] = 1'b1;
                pk_e[1] = EW'(e);
            end
        end
        pk_v[1] = pk_v[1] && (pk_e[1] != pk_e[0]);
    end

    // One search engine and one file read port per resolver
    for (genvar k = 0; k < NRES; k++) begin : g_res
        always_comb begin
            pk_blk[k] = BW'(pk_e[k] / EW'(QD));
            rf_ra[k]  = {blk_thr[pk_blk[k]], rq_reg[pk_e[k]]};
        end

        rf_wq_search #(
            .NBLK(NBLK), .QD(QD), .RW(RW), .TW(TW), .DW(DW)
        ) u_search (
            .rd_blk   (pk_blk[k]),
            .rd_thr   (blk_thr[pk_blk[k]]),
            .rd_reg   (rq_reg[pk_e[k]]),
            .live     (live),
            .blk_thr  (blk_thr),
            .older    (older),
            .wq_vld   (wq_vld),
            .wq_hv    (wq_hv),
            .wq_reg   (wq_reg),
            .wq_data  (wq_data),
            .byp_vld  (wval_vld),
            .byp_e    (wval_e),
            .byp_data (wval_data),
            .hit      (rs_hit[k]),
            .hit_rdy  (rs_rdy[k]),
            .hit_e    (rs_e[k]),
            .hit_data (rs_data[k])
        );
    end

    rf_bank_store #(.DEPTH(NTHR*NREG), .DW(DW)) u_store (
        .clk (clk),
        .rst_n (rst_n),
        .ra0 (rf_ra[0]),
        .rd0 (rf_q[0]),
        .ra1 (rf_ra[1]),
        .rd1 (rf_q[1]),
        .we  (rf_we),
        .wa  (rf_wa),
        .wd  (wq_data[cmt_e])
    );

    rf_age_matrix #(.NBLK(NBLK)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_vld (open_vld),
        .open_blk (open_blk),
        .blk_vld  (blk_vld),
        .older    (older)
    );

    // Lowest ready read of a live block goes to the output port
    always_comb begin
        em_vld = 1'b0;
        em_e   = '0;
        for (int e = NE-1; e >= 0; e--) begin
            if (rq_st[e] == RS_RDY && live[e/QD]) begin
                em_vld = 1'b1;
                em_e   = EW'(e);
            end
        end
    end

    // Read-queue entries: insert, resolve, park, wake, re-resolve, deliver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NE; e++) begin
                rq_st[e]   <= RS_IDLE;
                rq_reg[e]  <= '0;
                rq_tag[e]  <= '0;
                rq_data[e] <= '0;
                rq_pe[e]   <= '0;
            end
        end else begin
            for (int e = 0; e < NE; e++) begin
                if (free_v[e/QD]) begin
                    rq_st[e] <= RS_IDLE;
                end else if (rins_vld && rins_e == EW'(e)) begin
                    rq_st[e]  <= RS_NEW;
                    rq_reg[e] <= rins_reg;
                    rq_tag[e] <= rins_tag;
                end else if (pk_v[0] && pk_e[0] == EW'(e)) begin
                    rq_st[e]   <= (rs_hit[0] && !rs_rdy[0]) ? RS_PARK : RS_RDY;
                    rq_data[e] <= rs_hit[0] ? rs_data[0] : rf_q[0];
                    rq_pe[e]   <= rs_e[0];
                end else if (pk_v[1] && pk_e[1] == EW'(e)) begin
                    rq_st[e]   <= (rs_hit[1] && !rs_rdy[1]) ? RS_PARK : RS_RDY;
                    rq_data[e] <= rs_hit[1] ? rs_data[1] : rf_q[1];
                    rq_pe[e]   <= rs_e[1];
                end else if (rq_st[e] == RS_PARK && kill[rq_pe[e] / EW'(QD)]) begin
                    rq_st[e] <= RS_NEW;
                end else if (rq_st[e] == RS_PARK && wval_vld &&
                             wval_e == rq_pe[e] && wq_vld[wval_e]) begin
                    rq_st[e]   <= RS_RDY;
                    rq_data[e] <= wval_data;
                end else if (rq_st[e] == RS_RDY && em_vld && em_e == EW'(e)) begin
                    rq_st[e] <= RS_IDLE;
                end
            end
        end
    end

    // Registered operand output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_vld  <= 1'b0;
            op_tag  <= '0;
            op_data <= '0;
        end else begin
            op_vld  <= em_vld;
            op_tag  <= rq_tag[em_e];
            op_data <= rq_data[em_e];
        end
    end

    // Commit walker: one write-queue entry per cycle through the write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmt_busy <= 1'b0;
            cmt_b    <= '0;
            cmt_ptr  <= '0;
        end else if (!cmt_busy) begin
            if (cmt_vld) begin
                cmt_busy <= 1'b1;
                cmt_b    <= cmt_blk;
                cmt_ptr  <= '0;
            end
        end else begin
            cmt_ptr <= cmt_ptr + 1'b1;
            if (cmt_last) cmt_busy <= 1'b0;
        end
    end

    // File write request of the walker
    always_comb begin
        rf_we = cmt_busy && wq_vld[cmt_e] && wq_hv[cmt_e];
        rf_wa = {blk_thr[cmt_b], wq_reg[cmt_e]};
    end

    rf_done_chain #(.NBLK(NBLK)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_vld   (open_vld),
        .open_blk   (open_blk),
        .local_done (local_done),
        .cin_vld    (cin_vld),
        .cin_blk    (cin_blk),
        .cout_vld   (cout_vld),
        .cout_blk   (cout_blk)
    );

endmodule

// File: rtl/rf_fwd_bank_chk.sv
// Protocol checks for rf_fwd_bank, attached with bind below.
module rf_fwd_bank_chk #(
    parameter int NBLK = 8,
    parameter int QD   = 8,
    parameter int BW   = $clog2(NBLK)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_vld,
    input logic            cout_vld,
    input logic [BW-1:0]   cout_blk,
    input logic            cmt_vld,
    input logic            cmt_ready,
    input logic            flush_vld,
    input logic [NBLK-1:0] flush_mask,
    input logic            wins_vld,
    input logic [NBLK-1:0] wq_blk_any
);

    localparam int CNTW = $clog2(QD+1) + 1;
    logic [CNTW-1:0] busy_cnt;

    // Count consecutive cycles with commit not accepted
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_cnt <= '0;
        else if (!cmt_ready) busy_cnt <= busy_cnt + 1'b1;
        else                 busy_cnt <= '0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!op_vld && !cout_vld && cmt_ready));

    // R7
    commit_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_vld && cmt_ready) |=> !cmt_ready);

    // R7
    commit_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_ready || busy_cnt < CNTW'(QD)) &&
        ($rose(cmt_ready) -> busy_cnt == CNTW'(QD)));

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_vld && !wins_vld) |=> ((wq_blk_any & $past(flush_mask)) == '0));

    // R9
    single_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cout_vld |=> !(cout_vld && cout_blk == $past(cout_blk)));

endmodule

bind rf_fwd_bank rf_fwd_bank_chk #(.NBLK(NBLK), .QD(QD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_vld     (op_vld),
    .cout_vld   (cout_vld),
    .cout_blk   (cout_blk),
    .cmt_vld    (cmt_vld),
    .cmt_ready  (cmt_ready),
    .flush_vld  (flush_vld),
    .flush_mask (flush_mask),
    .wins_vld   (wins_vld),
    .wq_blk_any (wq_blk_any)
);

// File: tb/rf_fwd_bank_bench.sv
// Self-checking bench: full register sweeps plus forwarding scenarios.
module rf_fwd_bank_bench;

    localparam int DW = 16, NTHR = 4, NREG = 32, NBLK = 8, QD = 8, TAGW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic            open_vld = 0;  logic [2:0] open_blk = 0;
    logic [1:0]      open_thr = 0;  logic [3:0] open_nwr = 0;
    logic            wins_vld = 0;  logic [2:0] wins_blk = 0;
    logic [2:0]      wins_slot = 0; logic [4:0] wins_reg = 0;
    logic            rins_vld = 0;  logic [2:0] rins_blk = 0;
    logic [2:0]      rins_slot = 0; logic [4:0] rins_reg = 0;
    logic [TAGW-1:0] rins_tag = 0;
    logic            wval_vld = 0;  logic [2:0] wval_blk = 0;
    logic [2:0]      wval_slot = 0; logic [DW-1:0] wval_data = 0;
    logic            cmt_vld = 0;   logic [2:0] cmt_blk = 0;
    logic            cmt_ready;
    logic            flush_vld = 0; logic [NBLK-1:0] flush_mask = 0;
    logic            cin_vld = 0;   logic [2:0] cin_blk = 0;
    logic            cout_vld;      logic [2:0] cout_blk;
    logic            op_vld;        logic [TAGW-1:0] op_tag;
    logic [DW-1:0]   op_data;

    rf_fwd_bank #(.DW(DW), .NTHR(NTHR), .NREG(NREG), .NBLK(NBLK), .QD(QD),
                  .TAGW(TAGW)) u_rf_fwd_bank (.*);

    int n_chk = 0, n_bad = 0;
    int got_cnt [256];
    int got_dat [256];
    int cout_cnt [8];

    // Collect outputs away from the active edge
    always @(negedge clk) begin
        if (rst_n && op_vld) begin
            got_cnt[op_tag] = got_cnt[op_tag] + 1;
            got_dat[op_tag] = int'(op_data);
        end
        if (rst_n && cout_vld) cout_cnt[cout_blk] = cout_cnt[cout_blk] + 1;
    end

    function automatic int fv(int t, int r);
        return (t * 1000 + r * 7 + 5) & 16'hffff;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clr_got();
        for (int i = 0; i < 256; i++) begin got_cnt[i] = 0; got_dat[i] = 0; end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_open(int b, int t, int n);
        open_vld = 1; open_blk = 3'(b); open_thr = 2'(t); open_nwr = 4'(n);
        @(negedge clk); open_vld = 0;
    endtask

    task automatic do_wins(int b, int s, int r);
        wins_vld = 1; wins_blk = 3'(b); wins_slot = 3'(s); wins_reg = 5'(r);
        @(negedge clk); wins_vld = 0;
    endtask

    task automatic do_rins(int b, int s, int r, int tag);
        rins_vld = 1; rins_blk = 3'(b); rins_slot = 3'(s); rins_reg = 5'(r);
        rins_tag = TAGW'(tag);
        @(negedge clk); rins_vld = 0;
    endtask

    task automatic do_wval(int b, int s, int v);
        wval_vld = 1; wval_blk = 3'(b); wval_slot = 3'(s); wval_data = DW'(v);
        @(negedge clk); wval_vld = 0;
    endtask

    task automatic do_flush(int m);
        flush_vld = 1; flush_mask = NBLK'(m);
        @(negedge clk); flush_vld = 0;
    endtask

    task automatic do_cin(int b);
        cin_vld = 1; cin_blk = 3'(b);
        @(negedge clk); cin_vld = 0;
    endtask

    // Commit a block and return the number of cycles cmt_ready stayed low
    task automatic do_commit(int b, output int low);
        while (!cmt_ready) @(negedge clk);
        cmt_vld = 1; cmt_blk = 3'(b);
        @(negedge clk); cmt_vld = 0;
        low = 0;
        while (!cmt_ready && low < 100) begin low++; @(negedge clk); end
    endtask

    task automatic expect_op(int tag, int exp, string req, string what);
        chk(got_cnt[tag] == 1, req, {what, " count"}, got_cnt[tag], 1);
        chk(got_dat[tag] == exp, req, what, got_dat[tag], exp);
    endtask

    // Read every register of every thread and compare
    task automatic sweep(bit zero, string req);
        for (int t = 0; t < NTHR; t++) begin
            for (int g = 0; g < NREG / QD; g++) begin
                clr_got();
                do_open(0, t, 0);
                for (int s = 0; s < QD; s++) do_rins(0, s, g * QD + s, s);
                idle(12);
                for (int s = 0; s < QD; s++)
                    expect_op(s, zero ? 0 : fv(t, g * QD + s), req, "file read");
                do_flush(1);
            end
        end
    endtask

    bit done = 0;

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int low;
        for (int i = 0; i < 8; i++) cout_cnt[i] = 0;
        clr_got();
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: quiet outputs after reset
        chk(op_vld == 0, "R1", "op_vld", int'(op_vld), 0);
        chk(cout_vld == 0, "R1", "cout_vld", int'(cout_vld), 0);
        chk(cmt_ready == 1, "R1", "cmt_ready", int'(cmt_ready), 1);
        // R1 and R10: every register reads zero, one operand per read
        sweep(1'b1, "R1");

        // R7: fill the file through commits
        for (int t = 0; t < NTHR; t++) begin
            for (int g = 0; g < NREG / QD; g++) begin
                do_open(1, t, QD);
                for (int s = 0; s < QD; s++) do_wins(1, s, g * QD + s);
                for (int s = 0; s < QD; s++) do_wval(1, s, fv(t, g * QD + s));
                do_commit(1, low);
                chk(low == QD, "R7", "commit busy cycles", low, QD);
            end
        end
        // R2 and R7: committed values come back from the file
        sweep(1'b0, "R2");

        // R3 R5 R6: forwarding among several older writers
        clr_got();
        do_open(2, 1, 2); do_wins(2, 0, 5); do_wins(2, 1, 6);
        do_wval(2, 0, 16'h1111); do_wval(2, 1, 16'h2222);
        do_open(3, 1, 1); do_wins(3, 0, 5); do_wval(3, 0, 16'h3333);
        do_open(5, 2, 1); do_wins(5, 0, 5); do_wval(5, 0, 16'h5555);
        do_open(4, 1, 1); do_wins(4, 0, 7); do_wval(4, 0, 16'h7777);
        do_open(0, 1, 1); do_wins(0, 0, 8); do_wval(0, 0, 16'h0888);
        do_rins(4, 0, 5, 0); do_rins(4, 1, 6, 1); do_rins(4, 2, 7, 2);
        do_rins(4, 3, 8, 3); do_rins(4, 4, 9, 4);
        do_open(6, 2, 0); do_rins(6, 0, 5, 5); do_rins(6, 1, 6, 6);
        do_open(7, 3, 0); do_rins(7, 0, 5, 7);
        idle(16);
        expect_op(0, 16'h3333, "R5", "youngest older writer");
        expect_op(1, 16'h2222, "R3", "forward valued write");
        expect_op(2, fv(1, 7), "R6", "own-block write ignored");
        expect_op(3, fv(1, 8), "R5", "younger block ignored");
        expect_op(4, fv(1, 9), "R2", "no writer reads file");
        expect_op(5, 16'h5555, "R3", "thread 2 forward");
        expect_op(6, fv(2, 6), "R5", "other thread write ignored");
        expect_op(7, fv(3, 5), "R5", "thread 3 untouched");
        do_flush(8'hff);

        // R4: park until the value arrives
        clr_got();
        do_open(0, 0, 1); do_wins(0, 0, 9);
        do_open(1, 0, 0); do_rins(1, 0, 9, 10);
        idle(10);
        chk(got_cnt[10] == 0, "R4", "no operand while pending", got_cnt[10], 0);
        do_wval(0, 0, 16'h0999);
        idle(6);
        expect_op(10, 16'h0999, "R4", "woken value");
        do_flush(8'hff);

        // R8: parked read re-resolves after its writer is flushed
        clr_got();
        do_open(2, 0, 1); do_wins(2, 0, 10); do_wval(2, 0, 16'h4444);
        do_open(3, 0, 1); do_wins(3, 0, 10);
        do_open(4, 0, 0); do_rins(4, 0, 10, 20);
        idle(6);
        chk(got_cnt[20] == 0, "R4", "parked behind youngest", got_cnt[20], 0);
        do_flush(1 << 3);
        idle(6);
        expect_op(20, 16'h4444, "R8", "re-resolve to older write");
        do_open(5, 0, 1); do_wins(5, 0, 11);
        do_open(6, 0, 0); do_rins(6, 0, 11, 21);
        idle(6);
        do_flush(1 << 5);
        idle(6);
        expect_op(21, fv(0, 11), "R8", "re-resolve to file");
        do_wval(5, 0, 16'haaaa);
        do_open(1, 0, 0); do_rins(1, 0, 11, 22);
        idle(6);
        expect_op(22, fv(0, 11), "R8", "stale value ignored");
        // R7: commit of block 2 makes its write visible in the file
        do_commit(2, low);
        do_flush(8'hff);
        do_open(0, 0, 0); do_rins(0, 0, 10, 23);
        idle(6);
        expect_op(23, 16'h4444, "R7", "committed write in file");
        do_flush(8'hff);

        // R9: write completion relay in both orders and with no writes
        for (int i = 0; i < 8; i++) cout_cnt[i] = 0;
        do_open(3, 1, 2); do_wins(3, 0, 1); do_wins(3, 1, 2);
        do_wval(3, 0, 1); do_cin(3);
        idle(6);
        chk(cout_cnt[3] == 0, "R9", "held for local writes", cout_cnt[3], 0);
        do_wval(3, 1, 2);
        idle(6);
        chk(cout_cnt[3] == 1, "R9", "reported after local", cout_cnt[3], 1);
        idle(10);
        chk(cout_cnt[3] == 1, "R9", "reported once", cout_cnt[3], 1);
        do_open(4, 1, 1); do_wins(4, 0, 3); do_wval(4, 0, 3);
        idle(6);
        chk(cout_cnt[4] == 0, "R9", "held for neighbour", cout_cnt[4], 0);
        do_cin(4);
        idle(4);
        chk(cout_cnt[4] == 1, "R9", "reported after neighbour", cout_cnt[4], 1);
        do_open(5, 2, 0); do_cin(5);
        idle(4);
        chk(cout_cnt[5] == 1, "R9", "zero-write block", cout_cnt[5], 1);

        // R10: nothing extra appeared on the operand port
        begin
            int extra = 0;
            for (int i = 24; i < 256; i++) extra += got_cnt[i];
            chk(extra == 0, "R10", "unexpected operands", extra, 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule